// File: doc/BRIEF.md
# Almost-Flag Offset Programming Controller

This block decides the four almost-empty and almost-full thresholds used by a pair of FIFOs that move data in opposite directions between port A and port B. When a FIFO reset is released, the block takes in a two-bit select value. A non-zero select puts one of three fixed threshold values into the two offsets that belong to that FIFO. A zero select, with both FIFO resets released in the same cycle, starts a programming phase. During that phase the next four port-A writes do not go into FIFO memory. They are captured, in a fixed order, as the four offsets.

The block holds off normal writes into the port-A FIFO, and port-B input-ready, until its offsets are settled. A done output carries this state. The FIFO storage and the flag arithmetic sit outside the block. Everything runs on one clock, and a global synchronous active-low reset clears the controller. Each FIFO reset is a synchronous active-low level input, and the block watches it for its rising edge.

Top module: `ofs_prog_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, `prog_done` is 0, `fifo1_wr_en` is 0 and all four offsets are 0.
- R2: If `fsel` is 2'b11 in the cycle where a FIFO reset is first sampled high, that FIFO's two offsets are set to 64 at that edge.
- R3: A select of 2'b10 at release loads 16, and a select of 2'b01 loads 8.
- R4: A release of `fifo1_rst_n` loads only `af_a_ofs` and `ae_b_ofs`. A release of `fifo2_rst_n` loads only `af_b_ofs` and `ae_a_ofs`. The two resets may be released in different cycles.
- R5: If the select is 2'b00 and both FIFO resets rise at the same edge, a programming phase starts. The 1st, 2nd, 3rd and 4th port-A writes after that (`a_wr_en` high at an edge) load `af_a_ofs`, `ae_b_ofs`, `af_b_ofs` and `ae_a_ofs`, in that order, from `a_data_lo`. Bit 7 of `a_data_lo` is the MSB.
- R6: While `prog_done` is 0, `fifo1_wr_en` stays 0. None of the four programming writes reaches FIFO memory.
- R7: A programming value of 0 is stored as 1. A value above 252 (DEPTH-4) is stored as 252. Values from 1 to 252 are stored unchanged.
- R8: `prog_done` rises after the edge that captures the fourth programming write. From then on, `fifo1_wr_en` follows `a_wr_en`.
- R9: In preset mode, `prog_done` is 1 after the first edge at which both FIFO resets are sampled high.
- R10: A low on either FIFO reset drives `prog_done` to 0 after the next edge. The offsets keep their values until a new load.
- R11: A select of 2'b00 when the FIFO resets are not released together starts no programming phase and changes no offset. `prog_done` rises once both are high.
- R12: Once `prog_done` is 1, changes on `fsel`, `a_wr_en` or `a_data_lo` leave all four offsets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global synchronous active-low reset |
| fifo1_rst_n | input | 1 | Port A to B FIFO reset, active low, synchronous |
| fifo2_rst_n | input | 1 | Port B to A FIFO reset, active low, synchronous |
| fsel | input | 2 | Offset load method select, sampled at reset release |
| a_wr_en | input | 1 | Port-A write request |
| a_data_lo | input | 8 | Low bits of port-A write data |
| af_a_ofs | output | 8 | Port-A almost-full offset |
| ae_b_ofs | output | 8 | Port-B almost-empty offset |
| af_b_ofs | output | 8 | Port-B almost-full offset |
| ae_a_ofs | output | 8 | Port-A almost-empty offset |
| prog_done | output | 1 | Offsets settled; enables normal operation and port-B input-ready |
| fifo1_wr_en | output | 1 | Write strobe passed on to FIFO 1 memory |

## Verification
The assertions assume that the FIFO resets and the port-A inputs change only between clock edges, and that each FIFO reset is a level sampled once per cycle. No offset may move while `prog_done` is held. The bench drives every input on the falling edge, and it keeps `a_wr_en` low while either FIFO reset is low. Randomised trials mix paired and staggered releases with all four select codes. The programming data includes 0, 252, 253 and 255, so that the clamp bounds are exercised.

// File: rtl/ofs_pkg.sv
// Shared types for the offset programming controller.
// Assumes four offset slots, numbered in programming order.
package ofs_pkg;
    // Sequencer phases
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_PROG = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_t;

    localparam int NUM_SLOTS = 4;
    localparam int NUM_FIFOS = 2;
    // Slot index equals programming order; slot/2 is the owning FIFO
    localparam int SLOT_AF_A = 0;
    localparam int SLOT_AE_B = 1;
    localparam int SLOT_AF_B = 2;
    localparam int SLOT_AE_A = 3;
endpackage

// File: rtl/ofs_rise_detect.sv
// Detects a low-to-high change of a synchronous level input.
// Assumes the level is already synchronous to clk. During global reset the
// history is cleared to 0 (treated as "in reset"), so a level that is
// already high when rst_n releases gives one rise pulse.
module ofs_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    // Remember last sampled level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/ofs_prog_seq.sv
// Phase sequencer: waits for FIFO reset release, runs the four-write
// programming phase when asked, then enters run. Assumes lvl inputs are
// synchronous; any low level returns to the wait phase.
module ofs_prog_seq
    import ofs_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS,
    localparam int CW   = $clog2(SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_FIFOS-1:0]   lvl,
    input  logic [NUM_FIFOS-1:0]   rise,
    input  logic                   sel_par,
    input  logic                   wr_req,
    output logic                   cap_en,
    output logic [CW-1:0]          cap_idx,
    output logic                   done
);
    localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

    seq_state_t state_q;
    logic [CW-1:0] cnt_q;
    logic all_up;

    assign all_up  = &lvl;
    assign cap_en  = (state_q == ST_PROG) && wr_req && all_up;
    assign cap_idx = cnt_q;
    assign done    = (state_q == ST_RUN);

    // Phase and slot counter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
        end else if (!all_up) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_WAIT: begin
                    cnt_q <= '0;
                    if ((&rise) && sel_par) state_q <= ST_PROG;
                    else                    state_q <= ST_RUN;
                end
                ST_PROG: begin
                    if (wr_req) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == LAST) state_q <= ST_RUN;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/ofs_reg_bank.sv
// Holds the offset slots. A capture writes one clamped slot; a preset load
// writes both slots of the owning FIFO. A capture wins over a preset (they
// cannot coincide in normal use).
module ofs_reg_bank
    import ofs_pkg::*;
#(
    parameter int OFS_W   = 8,
    parameter int OFS_MAX = 252,
    parameter int SLOTS   = NUM_SLOTS,
    localparam int CW     = $clog2(SLOTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_FIFOS-1:0]        preset_ld,
    input  logic [OFS_W-1:0]            preset_val,
    input  logic                        cap_en,
    input  logic [CW-1:0]               cap_idx,
    input  logic [OFS_W-1:0]            cap_data,
    output logic [SLOTS-1:0][OFS_W-1:0] ofs
);
    localparam logic [OFS_W-1:0] MAXV = OFS_W'(OFS_MAX);
    localparam logic [OFS_W-1:0] MINV = OFS_W'(1);

    logic [OFS_W-1:0] clamped;

    // Force captured value into the legal range
    always_comb begin
        if (cap_data < MINV)      clamped = MINV;
        else if (cap_data > MAXV) clamped = MAXV;
        else                      clamped = cap_data;
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam int OWNER = g / 2;
        // One offset slot
        always_ff @(posedge clk) begin
            if (!rst_n)                             ofs[g] <= '0;
            else if (cap_en && cap_idx == CW'(g))   ofs[g] <= clamped;
            else if (preset_ld[OWNER])              ofs[g] <= preset_val;
        end
    end
endmodule

// File: rtl/ofs_prog_ctrl.sv
// Top: almost-flag offset programming controller for a FIFO pair.
// Assumes one clock, synchronous active-low resets, and that fsel is held
// stable around reset release. Outputs are registered except fifo1_wr_en.
module ofs_prog_ctrl
    import ofs_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int PRESET_LG = 64,
    parameter int PRESET_MD = 16,
    parameter int PRESET_SM = 8,
    localparam int OFS_W    = $clog2(DEPTH),
    localparam int OFS_MAX  = DEPTH - 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo1_rst_n,
    input  logic             fifo2_rst_n,
    input  logic [1:0]       fsel,
    input  logic             a_wr_en,
    input  logic [OFS_W-1:0] a_data_lo,
    output logic [OFS_W-1:0] af_a_ofs,
    output logic [OFS_W-1:0] ae_b_ofs,
    output logic [OFS_W-1:0] af_b_ofs,
    output logic [OFS_W-1:0] ae_a_ofs,
    output logic             prog_done,
    output logic             fifo1_wr_en
);
    localparam int CW = $clog2(NUM_SLOTS);

    logic [NUM_FIFOS-1:0] lvl, rise, preset_ld;
    logic [OFS_W-1:0]     preset_val;
    logic                 sel_par, cap_en, done;
    logic [CW-1:0]        cap_idx;
    logic [NUM_SLOTS-1:0][OFS_W-1:0] ofs;

    assign lvl = {fifo2_rst_n, fifo1_rst_n};

    for (genvar f = 0; f < NUM_FIFOS; f++) begin : g_rise
        ofs_rise_detect u_rise (
            .clk  (clk),
            .rst_n(rst_n),
            .lvl  (lvl[f]),
            .rise (rise[f])
        );
    end

    // Decode the select into a preset value
    always_comb begin
        case (fsel)
            2'b11:   preset_val = OFS_W'(PRESET_LG);
            2'b10:   preset_val = OFS_W'(PRESET_MD);
            2'b01:   preset_val = OFS_W'(PRESET_SM);
            default: preset_val = '0;
        endcase
    end

    assign sel_par   = (fsel == 2'b00);
    assign preset_ld = sel_par ? '0 : rise;

    ofs_prog_seq #(.SLOTS(NUM_SLOTS)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl    (lvl),
        .rise   (rise),
        .sel_par(sel_par),
        .wr_req (a_wr_en),
        .cap_en (cap_en),
        .cap_idx(cap_idx),
        .done   (done)
    );

    ofs_reg_bank #(.OFS_W(OFS_W), .OFS_MAX(OFS_MAX), .SLOTS(NUM_SLOTS)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .preset_ld (preset_ld),
        .preset_val(preset_val),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .cap_data  (a_data_lo),
        .ofs       (ofs)
    );

    assign af_a_ofs    = ofs[SLOT_AF_A];
    assign ae_b_ofs    = ofs[SLOT_AE_B];
    assign af_b_ofs    = ofs[SLOT_AF_B];
    assign ae_a_ofs    = ofs[SLOT_AE_A];
    assign prog_done   = done;
    assign fifo1_wr_en = a_wr_en & done;
endmodule

// File: rtl/ofs_prog_ctrl_chk.sv
// Checker for ofs_prog_ctrl, watching its ports only.
module ofs_prog_ctrl_chk #(
    parameter int OFS_W   = 8,
    parameter int OFS_MAX = 252
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo1_rst_n,
    input logic             fifo2_rst_n,
    input logic             a_wr_en,
    input logic [OFS_W-1:0] af_a_ofs,
    input logic [OFS_W-1:0] ae_b_ofs,
    input logic [OFS_W-1:0] af_b_ofs,
    input logic [OFS_W-1:0] ae_a_ofs,
    input logic             prog_done,
    input logic             fifo1_wr_en
);
    // R1: global reset clears outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!prog_done && af_a_ofs == 0 && ae_b_ofs == 0 &&
                    af_b_ofs == 0 && ae_a_ofs == 0));

    // R10: a FIFO reset drops done
    p_fifo_rst_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo1_rst_n || !fifo2_rst_n) |=> !prog_done);

    // R12: offsets frozen while done
    p_frozen_when_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done |=> ($stable(af_a_ofs) && $stable(ae_b_ofs) &&
                       $stable(af_b_ofs) && $stable(ae_a_ofs)));

    // R7: a changed offset lands inside the legal range
    p_af_a_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(af_a_ofs) |-> (af_a_ofs >= 1 && af_a_ofs <= OFS_MAX));
    p_ae_b_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ae_b_ofs) |-> (ae_b_ofs >= 1 && ae_b_ofs <= OFS_MAX));
    p_af_b_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(af_b_ofs) |-> (af_b_ofs >= 1 && af_b_ofs <= OFS_MAX));
    p_ae_a_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ae_a_ofs) |-> (ae_a_ofs >= 1 && ae_a_ofs <= OFS_MAX));

    // R6: no FIFO write before done
    p_no_early_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo1_wr_en |-> (prog_done && a_wr_en && fifo1_rst_n));
endmodule

bind ofs_prog_ctrl ofs_prog_ctrl_chk #(.OFS_W(OFS_W), .OFS_MAX(OFS_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo1_rst_n(fifo1_rst_n),
    .fifo2_rst_n(fifo2_rst_n),
    .a_wr_en    (a_wr_en),
    .af_a_ofs   (af_a_ofs),
    .ae_b_ofs   (ae_b_ofs),
    .af_b_ofs   (af_b_ofs),
    .ae_a_ofs   (ae_a_ofs),
    .prog_done  (prog_done),
    .fifo1_wr_en(fifo1_wr_en)
);

// File: tb/tb_ofs_prog_ctrl.sv
`timescale 1ns/1ps
module tb_ofs_prog_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo1_rst_n = 1'b0, fifo2_rst_n = 1'b0;
    logic [1:0] fsel = 2'b00;
    logic a_wr_en = 1'b0;
    logic [7:0] a_data_lo = 8'h00;
    logic [7:0] af_a_ofs, ae_b_ofs, af_b_ofs, ae_a_ofs;
    logic prog_done, fifo1_wr_en;

    int checks = 0, errors = 0;
    bit finished = 0;
    int exp_ofs [4];
    bit exp_done = 0, exp_prog = 0;
    int exp_cnt = 0;

    always #4 clk = ~clk;

    ofs_prog_ctrl dut (.*);

    function automatic int preset_of(logic [1:0] s);
        case (s)
            2'b11: return 64;
            2'b10: return 16;
            2'b01: return 8;
            default: return -1;
        endcase
    endfunction

    function automatic int clamp_of(int v);
        if (v < 1) return 1;
        if (v > 252) return 252;
        return v;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic check_all(string req);
        #1;
        chk(af_a_ofs == exp_ofs[0], {req, " af_a"}, af_a_ofs, exp_ofs[0]);
        chk(ae_b_ofs == exp_ofs[1], {req, " ae_b"}, ae_b_ofs, exp_ofs[1]);
        chk(af_b_ofs == exp_ofs[2], {req, " af_b"}, af_b_ofs, exp_ofs[2]);
        chk(ae_a_ofs == exp_ofs[3], {req, " ae_a"}, ae_a_ofs, exp_ofs[3]);
        chk(prog_done == exp_done, {req, " done"}, prog_done, exp_done);
    endtask

    // Hold both FIFO resets low for two cycles (R10)
    task automatic fifo_reset();
        @(negedge clk);
        fifo1_rst_n = 0; fifo2_rst_n = 0; a_wr_en = 0;
        @(negedge clk);
        exp_done = 0; exp_prog = 0; exp_cnt = 0;
        check_all("R10");
        @(negedge clk);
    endtask

    // Release one or both FIFO resets with a select value
    task automatic release_rst(bit r1, bit r2, logic [1:0] s, string req);
        bit ri1, ri2;
        @(negedge clk);
        ri1 = r1 && !fifo1_rst_n;
        ri2 = r2 && !fifo2_rst_n;
        if (r1) fifo1_rst_n = 1;
        if (r2) fifo2_rst_n = 1;
        fsel = s;
        @(negedge clk);
        if (preset_of(s) >= 0) begin
            if (ri1) begin exp_ofs[0] = preset_of(s); exp_ofs[1] = preset_of(s); end
            if (ri2) begin exp_ofs[2] = preset_of(s); exp_ofs[3] = preset_of(s); end
        end
        if (fifo1_rst_n && fifo2_rst_n && !exp_done && !exp_prog) begin
            if (ri1 && ri2 && s == 2'b00) exp_prog = 1;
            else exp_done = 1;
        end
        check_all(req);
    endtask

    // One port-A write; checks the pass-through strobe before the edge
    task automatic pwrite(logic [7:0] d, string req);
        @(negedge clk);
        a_wr_en = 1; a_data_lo = d;
        #1;
        chk(fifo1_wr_en == exp_done, "R6 R8 wr strobe", fifo1_wr_en, exp_done);
        @(negedge clk);
        a_wr_en = 0;
        if (exp_prog) begin
            exp_ofs[exp_cnt] = clamp_of(int'(d));
            exp_cnt++;
            if (exp_cnt == 4) begin exp_prog = 0; exp_done = 1; end
        end
        check_all(req);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4; i++) exp_ofs[i] = 0;
        repeat (3) @(negedge clk);
        check_all("R1");
        #1 chk(fifo1_wr_en == 0, "R1 wr strobe", fifo1_wr_en, 0);
        rst_n = 1;

        // R2 and R9: paired release with 11
        release_rst(1, 1, 2'b11, "R2 R9");
        pwrite(8'h33, "R8 R12");
        // R3
        fifo_reset();
        release_rst(1, 1, 2'b10, "R3");
        fifo_reset();
        release_rst(1, 1, 2'b01, "R3");
        // R4: staggered presets
        fifo_reset();
        release_rst(1, 0, 2'b11, "R4");
        release_rst(0, 1, 2'b10, "R4");
        // R11: 00 unpaired
        fifo_reset();
        release_rst(1, 0, 2'b00, "R11");
        release_rst(0, 1, 2'b00, "R11");
        // R5 R7: programming with clamp corners
        fifo_reset();
        release_rst(1, 1, 2'b00, "R5");
        pwrite(8'd0,   "R5 R7 zero");
        pwrite(8'd253, "R5 R7 above");
        pwrite(8'd252, "R5 R7 top");
        pwrite(8'd1,   "R5 R8 last");
        // R12: fsel wiggle and extra writes do nothing
        @(negedge clk); fsel = 2'b11;
        @(negedge clk); check_all("R12 fsel");
        pwrite(8'd77, "R12 write");

        // Random trials
        for (int t = 0; t < 60; t++) begin
            logic [1:0] s1, s2;
            int mode;
            s1 = 2'($urandom_range(0, 3));
            s2 = 2'($urandom_range(0, 3));
            mode = $urandom_range(0, 2);
            fifo_reset();
            if (mode == 0) begin
                release_rst(1, 0, s1, "R4 R11 rand");
                release_rst(0, 1, s2, "R4 R11 rand");
            end else begin
                if (mode == 2) s1 = 2'b00;
                release_rst(1, 1, s1, "R2 R3 R5 rand");
            end
            for (int w = 0; w < 6; w++) begin
                logic [7:0] d;
                int k;
                k = $urandom_range(0, 5);
                if (k == 0) d = 8'd0;
                else if (k == 1) d = 8'd255;
                else d = 8'($urandom);
                if ($urandom_range(0, 3) == 0) begin
                    @(negedge clk); fsel = 2'($urandom_range(0, 3));
                end
                pwrite(d, "R5 R7 R8 R12 rand");
            end
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule